// File: doc/BRIEF.md
# LED Fault Scan Result Capture

This block is the fault-scan datapath of a serial-in, parallel-out LED sink driver with a parameterised number of channels (16 by default). In normal operation a serial stream enters a shift register on each serial clock strobe. A latch strobe copies the register into an output latch, and the latch drives the channel enables while the active-low output enable is low.

When the scan mode flag is set, the same path is used to test the LED strings. The host shifts in a word of ones and latches it. It then holds output enable low long enough for the sensing to settle. Per-channel open-line and shorted-LED comparator flags arrive as digital inputs and are sampled on each cycle that output enable is low. On the rising edge of output enable the shift register is loaded in parallel with one pass/fail bit per channel. Further serial clock strobes then carry the results out, highest channel first, in the same framing as display data. Each entry into scan mode yields exactly one capture. A second capture needs the mode flag to drop and rise again.

Top module: `led_det_capture`

## Requirements
- R1: After reset the serial output, all channel drives and the result-valid flag are 0.
- R2: On each clock edge with the serial clock strobe high and no capture, the register shifts toward its top bit, taking the serial input at bit 0. The serial output is always the top bit (channel N-1), so a word sent most-significant bit first reads back unchanged after N shifts.
- R3: A clock edge with the latch strobe high copies the shift register into the output latch. Channel drive i equals latch bit i while output enable is low, and every drive is 0 while output enable is high.
- R4: In scan mode, the first clock edge that samples output enable high after at least MIN_LOW consecutive edges that sampled it low is a capture. On that edge, result bit i becomes 0 if latch bit i is 1 and the open or short flag of channel i is set. Otherwise result bit i becomes 1.
- R5: Immediately after a capture the serial output shows the result of channel N-1. Each following strobe presents the next lower channel, down to channel 0.
- R6: A channel whose latch bit is 0 reports 1 (no fault), whatever its flags show.
- R7: A low period of output enable shorter than MIN_LOW edges causes no capture. The shift register keeps its contents and result-valid stays 0.
- R8: With the scan mode flag low, a rising output enable never captures, however long the low period was.
- R9: Only one capture happens per scan mode entry. Further low pulses of output enable are ignored until the mode flag has been low for at least one clock edge and is raised again.
- R10: Result-valid goes to 1 on the capture edge. It stays at 1 through the first N-1 strobes and clears on the edge of the Nth strobe.
- R11: The flags used for a capture are those sampled on the last edge at which output enable was low. Flag values present only on the capture edge itself have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_mode_i | input | 1 | Scan mode flag from the mode sequence decoder |
| sdi_i | input | 1 | Serial data input |
| sclk_en_i | input | 1 | Serial clock strobe, one shift per high cycle |
| latch_i | input | 1 | Latch strobe, copies shift register to output latch |
| oe_ni | input | 1 | Output enable, active low |
| open_i | input | N | Per-channel open-line / short-to-ground comparator flags |
| short_i | input | N | Per-channel shorted-LED comparator flags |
| sdo_o | output | 1 | Serial data output (top bit of the shift register) |
| drive_o | output | N | Per-channel sink enables |
| result_valid_o | output | 1 | Scan result held in shift register and not yet fully shifted out |

## Verification
The capture happens on the edge that first samples output enable high, so the serial output and result-valid change on that same edge. The bench checks them half a period later, before it issues any strobe. Each strobe moves the serial output to the next channel on its own edge, so every read samples the output before it raises that strobe. Drive outputs depend on output enable without a register but follow the latch one edge after the latch strobe, and the bench samples them one cycle after each change. A run of exactly MIN_LOW low edges and a run of MIN_LOW-1 low edges bracket the capture threshold.

// File: rtl/led_det_pkg.sv
package led_det_pkg;
  localparam int unsigned CH_DEF      = 16;
  localparam int unsigned MIN_LOW_DEF = 50;  // 1 us at 50 MHz
endpackage

// File: rtl/led_det_eval.sv
module led_det_eval #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_ni,
  input  logic [N-1:0] open_i,
  input  logic [N-1:0] short_i,
  input  logic [N-1:0] latch_i,
  output logic [N-1:0] res_o
);
  logic [N-1:0] flt_q;

  // flags frozen at the last low sample of output enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flt_q <= '0;
    else if (!oe_ni) flt_q <= open_i | short_i;
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    assign res_o[g] = ~(latch_i[g] & flt_q[g]);
  end
endmodule

// File: rtl/led_det_ctrl.sv
module led_det_ctrl #(
  parameter int unsigned N       = 16,
  parameter int unsigned MIN_LOW = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_mode_i,
  input  logic oe_ni,
  input  logic sclk_en_i,
  output logic cap_o,
  output logic valid_o
);
  localparam int unsigned LW = $clog2(MIN_LOW + 1);
  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;

  logic          oe_q;
  logic          done_q;
  logic [LW-1:0] low_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;

  assign cap_o   = det_mode_i & oe_ni & ~oe_q & (low_q == LW'(MIN_LOW)) & ~done_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q  <= 1'b1;
      low_q <= '0;
    end else begin
      oe_q <= oe_ni;
      if (oe_ni)                      low_q <= '0;
      else if (low_q != LW'(MIN_LOW)) low_q <= low_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (!det_mode_i) done_q <= 1'b0;
    else if (cap_o)       done_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (cap_o) begin
      valid_q <= 1'b1;
      cnt_q   <= '0;
    end else if (valid_q && sclk_en_i) begin
      if (cnt_q == CW'(N - 1)) begin
        valid_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_valid_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(cap_o));
endmodule

// File: rtl/led_det_shift.sv
module led_det_shift #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sdi_i,
  input  logic         sclk_en_i,
  input  logic         latch_i,
  input  logic         cap_i,
  input  logic [N-1:0] res_i,
  output logic         sdo_o,
  output logic [N-1:0] latch_o
);
  logic [N-1:0] sr_q;
  logic [N-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (cap_i)     sr_q <= res_i;
    else if (sclk_en_i) sr_q <= {sr_q[N-2:0], sdi_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= '0;
    else if (latch_i) lat_q <= sr_q;
  end

  assign sdo_o   = sr_q[N-1];
  assign latch_o = lat_q;

  p_shift_in_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_en_i && !cap_i |=> sr_q[0] == $past(sdi_i));
  p_latch_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> lat_q == $past(sr_q));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_en_i && !cap_i |=> $stable(sr_q));
endmodule

// File: rtl/led_det_capture.sv
module led_det_capture
  import led_det_pkg::*;
#(
  parameter int unsigned N       = CH_DEF,
  parameter int unsigned MIN_LOW = MIN_LOW_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         det_mode_i,
  input  logic         sdi_i,
  input  logic         sclk_en_i,
  input  logic         latch_i,
  input  logic         oe_ni,
  input  logic [N-1:0] open_i,
  input  logic [N-1:0] short_i,
  output logic         sdo_o,
  output logic [N-1:0] drive_o,
  output logic         result_valid_o
);
  logic         cap_w;
  logic [N-1:0] res_w;
  logic [N-1:0] lat_w;

  led_det_ctrl #(.N(N), .MIN_LOW(MIN_LOW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .det_mode_i(det_mode_i),
    .oe_ni     (oe_ni),
    .sclk_en_i (sclk_en_i),
    .cap_o     (cap_w),
    .valid_o   (result_valid_o)
  );

  led_det_eval #(.N(N)) u_eval (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .oe_ni  (oe_ni),
    .open_i (open_i),
    .short_i(short_i),
    .latch_i(lat_w),
    .res_o  (res_w)
  );

  led_det_shift #(.N(N)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdi_i    (sdi_i),
    .sclk_en_i(sclk_en_i),
    .latch_i  (latch_i),
    .cap_i    (cap_w),
    .res_i    (res_w),
    .sdo_o    (sdo_o),
    .latch_o  (lat_w)
  );

  assign drive_o = oe_ni ? '0 : lat_w;

  p_cap_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_w |-> det_mode_i);
  p_cap_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_w |=> sdo_o == $past(res_w[N-1]) && result_valid_o);
endmodule

// File: tb/led_det_capture_test.sv
module led_det_capture_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned N          = 16;
  localparam int unsigned MIN_LOW    = 6;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         det_mode_i = 1'b0, sdi_i = 1'b0, sclk_en_i = 1'b0, latch_i = 1'b0;
  logic         oe_ni = 1'b1;
  logic [N-1:0] open_i = '0, short_i = '0;
  logic         sdo_o;
  logic [N-1:0] drive_o;
  logic         result_valid_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  led_det_capture #(.N(N), .MIN_LOW(MIN_LOW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .det_mode_i(det_mode_i), .sdi_i(sdi_i),
    .sclk_en_i(sclk_en_i), .latch_i(latch_i), .oe_ni(oe_ni),
    .open_i(open_i), .short_i(short_i), .sdo_o(sdo_o), .drive_o(drive_o),
    .result_valid_o(result_valid_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic shift_word(input logic [N-1:0] w);
    for (int i = N - 1; i >= 0; i--) begin
      sdi_i = w[i]; sclk_en_i = 1'b1; cyc();
    end
    sclk_en_i = 1'b0; sdi_i = 1'b0;
  endtask

  task automatic latch_pulse();
    latch_i = 1'b1; cyc(); latch_i = 1'b0;
  endtask

  task automatic read_word(output logic [N-1:0] w, input bit chk_valid, input string tag);
    for (int k = 0; k < N; k++) begin
      if (chk_valid) check(tag, 32'(result_valid_o), 32'd1);
      w[N-1-k] = sdo_o;
      sdi_i = 1'b0; sclk_en_i = 1'b1; cyc();
    end
    sclk_en_i = 1'b0;
    if (chk_valid) check(tag, 32'(result_valid_o), 32'd0);
  endtask

  task automatic detect(input logic [N-1:0] o, input logic [N-1:0] s, input int lowcyc,
                        input logic [N-1:0] o2, input logic [N-1:0] s2);
    oe_ni = 1'b0; open_i = o; short_i = s;
    repeat (lowcyc) cyc();
    oe_ni = 1'b1; open_i = o2; short_i = s2;
    cyc();
    open_i = '0; short_i = '0;
  endtask

  function automatic logic [N-1:0] expect_res(input logic [N-1:0] l, input logic [N-1:0] o,
                                              input logic [N-1:0] s);
    return ~(l & (o | s));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] rd, l, o, s;
    repeat (3) cyc();
    check("R1 sdo", 32'(sdo_o), 0);
    check("R1 drive", 32'(drive_o), 0);
    check("R1 valid", 32'(result_valid_o), 0);
    rst_ni = 1'b1;
    cyc();

    // R2 shift path
    shift_word(16'hA53C);
    check("R2 top bit", 32'(sdo_o), 1);
    read_word(rd, 0, "R2");
    check("R2 readback", 32'(rd), 32'h0000A53C);

    // R3 latch and enable gating
    shift_word(16'h5AF0); latch_pulse();
    oe_ni = 1'b0; cyc();
    check("R3 drive on", 32'(drive_o), 32'h00005AF0);
    oe_ni = 1'b1; cyc();
    check("R3 drive off", 32'(drive_o), 0);

    // R8 no capture outside scan mode
    shift_word(16'h3C96);
    detect('1, '1, MIN_LOW + 3, '1, '1);
    check("R8 valid", 32'(result_valid_o), 0);
    read_word(rd, 0, "R8");
    check("R8 contents", 32'(rd), 32'h00003C96);

    // R4 R5 R10 R11 walking single faults, all channels driven
    for (int ch = 0; ch < N; ch++) begin
      shift_word('1); latch_pulse();
      det_mode_i = 1'b1; cyc();
      o = (ch % 2 == 0) ? (N'(1) << ch) : '0;
      s = (ch % 2 == 1) ? (N'(1) << ch) : '0;
      detect(o, s, MIN_LOW, ~o, ~s);
      check("R10 valid at capture", 32'(result_valid_o), 1);
      read_word(rd, ch == 0, "R10 span");
      check("R4 R5 R11 walking", 32'(rd), 32'(expect_res('1, o, s)));
      det_mode_i = 1'b0; cyc();
    end

    // R6 partial latch patterns with mixed faults
    for (int k = 1; k <= 8; k++) begin
      l = N'(16'hFFFF ^ (k * 16'h1357));
      o = N'(k * 16'h0F1D);
      s = N'(16'hC381 >> k);
      shift_word(l); latch_pulse();
      det_mode_i = 1'b1; cyc();
      detect(o, s, MIN_LOW + k, '0, '0);
      read_word(rd, 0, "R6");
      check("R6 undriven healthy", 32'(rd), 32'(expect_res(l, o, s)));
      det_mode_i = 1'b0; cyc();
    end

    // R7 low period one short of threshold
    shift_word(16'h8E71); latch_pulse();
    det_mode_i = 1'b1; cyc();
    detect('1, '1, MIN_LOW - 1, '1, '1);
    check("R7 valid", 32'(result_valid_o), 0);
    read_word(rd, 0, "R7");
    check("R7 contents", 32'(rd), 32'h00008E71);

    // R9 one capture per entry (still in mode after R7 shifts zeros in)
    shift_word('1); latch_pulse();
    detect(16'h0011, '0, MIN_LOW, '0, '0);
    read_word(rd, 0, "R9");
    check("R9 first capture", 32'(rd), 32'(expect_res('1, 16'h0011, '0)));
    detect('1, '1, MIN_LOW + 2, '1, '1);
    check("R9 no second valid", 32'(result_valid_o), 0);
    read_word(rd, 0, "R9");
    check("R9 no second capture", 32'(rd), 0);
    det_mode_i = 1'b0; cyc();
    det_mode_i = 1'b1; cyc();
    detect('0, 16'h8000, MIN_LOW, '0, '0);
    read_word(rd, 0, "R9");
    check("R9 re-entry capture", 32'(rd), 32'(expect_res('1, '0, 16'h8000)));
    det_mode_i = 1'b0; cyc();

    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule